// File: doc/BRIEF.md
# Serial DAC Load Sequencer

This block sits on the host side of a double-buffered serial digital-to-analog converter. Logic in the chip hands it a 12-bit code with a valid/ready handshake. The block then drives the converter's pins in a fixed order: select goes low, the 12 bits go out most significant bit first on a generated serial clock, select is released, and an active-low load strobe is pulsed. That pulse moves the shifted word into the converter's output register. A separate clear command produces an active-low clear pulse, which drives the converter's output code to zero.

Every interval is a parameter counted in system clock cycles: select setup, serial clock low time, serial clock high time, select hold after the last clock, load setup, load width and clear width. The sequence keeps the load strobe out of the shift phase, so the serial clock is never active while load is low. A clear request that arrives during a word transfer is held until the transfer is complete.

Top module: `dac_load_seq`

## Requirements
- R1: While reset is high and right after it, the pins rest idle: select high, serial clock low, data low, load high, clear high, busy low, ready high.
- R2: A word goes out as 12 bits, bit 11 first and bit 0 last. The data pin holds one bit for a whole low-plus-high clock period and changes only in the cycle where the serial clock falls. The data pin is low outside the shift phase.
- R3: Each bit gets T_CLK_LO cycles of serial clock low, then T_CLK_HI cycles high, which gives exactly 12 rising edges per word. The serial clock is low whenever select is high.
- R4: Select goes low in the cycle after the handshake. It stays low for T_SEL cycles before the first bit's low phase, and for T_CSH cycles after the last high phase ends.
- R5: After select rises, load stays high for T_LD_SETUP cycles and then is low for T_LD_W cycles. Load is never low while select is low or the serial clock is high.
- R6: After the load pulse there is one cycle with all pins at idle levels and busy still high. Only after that cycle is ready raised again.
- R7: A clear request while idle drives clear low for T_CLR_W cycles, starting in the cycle after the request. Clear is low only while select and load are both high.
- R8: A clear request during a word transfer does not alter that transfer. Its clear pulse begins in the cycle right after the transfer's final idle-level cycle. A clear request during a clear pulse causes one more pulse right after the current one.
- R9: Busy is high in every cycle that is not idle, including the select setup, shift, hold, load, final and clear cycles.
- R10: Ready is high only when idle. The code is captured when valid and ready are both high. Valid while busy has no effect, and neither do later changes to the code input.
- R11: If a request and a clear arrive in the same idle cycle, the word transfer runs first and the clear pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A code is offered |
| req_ready | output | 1 | The sequencer accepts a code (idle) |
| req_code | input | 12 | Code to send, sampled at the handshake |
| clr_req | input | 1 | Request a clear pulse |
| busy | output | 1 | High in every state but idle |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_sclk | output | 1 | Serial clock; the converter captures on the rising edge |
| dac_sdi | output | 1 | Serial data, MSB first |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
The properties assume the inputs are synchronous to the system clock and that reset is held high for at least one edge. They need nothing else of the inputs, because valid and clear may arrive in any cycle. The stimulus drives inputs only at falling clock edges. It covers valid held high through a busy period with a changing code, clear in idle, clear in the middle of a shift, clear during an active clear pulse, and clear together with a request. Back-to-back words come from valid staying high when the sequencer returns to idle.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SHIFT,
        ST_DESELECT,
        ST_LOAD,
        ST_DONE,
        ST_CLEAR
    } seq_state_e;

    // pin image produced by the sequencer
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
        logic ld_n;
        logic clr_n;
    } dac_pins_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dac_seq_shifter.sv
module dac_seq_shifter #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    import dac_seq_pkg::*;
    localparam int unsigned CW = width_for(W - 1);

    logic [W-1:0]  sreg;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= word;
            left <= CW'(W - 1);
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign msb  = sreg[W-1];
    assign last = (left == '0);

    // R2
    no_shift_past_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        shift |-> !last);
endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq #(
    parameter int unsigned WORD_W     = 12,
    parameter int unsigned T_SEL      = 2,
    parameter int unsigned T_CSH      = 2,
    parameter int unsigned T_CLK_LO   = 3,
    parameter int unsigned T_CLK_HI   = 2,
    parameter int unsigned T_LD_SETUP = 2,
    parameter int unsigned T_LD_W     = 3,
    parameter int unsigned T_CLR_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_code,
    input  logic              clr_req,
    output logic              busy,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_ld_n,
    output logic              dac_clr_n
);
    import dac_seq_pkg::*;

    localparam int unsigned TMAX = max2(max2(max2(T_SEL, T_CSH), max2(T_CLK_LO, T_CLK_HI)),
                                        max2(max2(T_LD_SETUP, T_LD_W), T_CLR_W));
    localparam int unsigned TW   = width_for(TMAX);

    localparam logic [TW-1:0] V_SEL = TW'(T_SEL - 1);
    localparam logic [TW-1:0] V_CSH = TW'(T_CSH - 1);
    localparam logic [TW-1:0] V_LO  = TW'(T_CLK_LO - 1);
    localparam logic [TW-1:0] V_HI  = TW'(T_CLK_HI - 1);
    localparam logic [TW-1:0] V_LDS = TW'(T_LD_SETUP - 1);
    localparam logic [TW-1:0] V_LDW = TW'(T_LD_W - 1);
    localparam logic [TW-1:0] V_CLR = TW'(T_CLR_W - 1);

    seq_state_e st, st_n;
    logic       ph, ph_n;
    logic       pend, pend_n;
    logic       tmr_ld, tmr_done;
    logic [TW-1:0] tmr_val;
    logic       sh_load, sh_shift, sh_msb, sh_last;
    logic       fire, clr_want;
    dac_pins_t  pins;

    dac_seq_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_done)
    );

    dac_seq_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .word(req_code),
        .shift(sh_shift), .msb(sh_msb), .last(sh_last)
    );

    assign req_ready = (st == ST_IDLE);
    assign fire      = req_valid && req_ready;
    assign clr_want  = pend || clr_req;

    always_comb begin
        st_n     = st;
        ph_n     = ph;
        pend_n   = pend;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (fire) begin
                    st_n    = ST_SELECT;
                    tmr_ld  = 1'b1;
                    tmr_val = V_SEL;
                    sh_load = 1'b1;
                    pend_n  = clr_req;
                end else if (clr_req) begin
                    st_n    = ST_CLEAR;
                    tmr_ld  = 1'b1;
                    tmr_val = V_CLR;
                end
            end
            ST_SELECT: begin
                pend_n = clr_want;
                if (tmr_done) begin
                    st_n    = ST_SHIFT;
                    ph_n    = 1'b0;
                    tmr_ld  = 1'b1;
                    tmr_val = V_LO;
                end
            end
            ST_SHIFT: begin
                pend_n = clr_want;
                if (tmr_done) begin
                    tmr_ld = 1'b1;
                    if (!ph) begin
                        ph_n    = 1'b1;
                        tmr_val = V_HI;
                    end else if (sh_last) begin
                        st_n    = ST_DESELECT;
                        ph_n    = 1'b0;
                        tmr_val = V_CSH;
                    end else begin
                        ph_n     = 1'b0;
                        sh_shift = 1'b1;
                        tmr_val  = V_LO;
                    end
                end
            end
            ST_DESELECT: begin
                pend_n = clr_want;
                if (tmr_done) begin
                    st_n    = ST_LOAD;
                    ph_n    = 1'b0;
                    tmr_ld  = 1'b1;
                    tmr_val = V_LDS;
                end
            end
            ST_LOAD: begin
                pend_n = clr_want;
                if (tmr_done) begin
                    tmr_ld = 1'b1;
                    if (!ph) begin
                        ph_n    = 1'b1;
                        tmr_val = V_LDW;
                    end else begin
                        st_n    = ST_DONE;
                        ph_n    = 1'b0;
                        tmr_val = '0;
                    end
                end
            end
            ST_DONE, ST_CLEAR: begin
                if (st == ST_DONE || tmr_done) begin
                    pend_n = 1'b0;
                    if (clr_want) begin
                        st_n    = ST_CLEAR;
                        tmr_ld  = 1'b1;
                        tmr_val = V_CLR;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else begin
                    pend_n = clr_want;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ph   <= 1'b0;
            pend <= 1'b0;
        end else begin
            st   <= st_n;
            ph   <= ph_n;
            pend <= pend_n;
        end
    end

    always_comb begin
        pins.cs_n  = !(st == ST_SELECT || st == ST_SHIFT || st == ST_DESELECT);
        pins.sclk  = (st == ST_SHIFT) && ph;
        pins.sdi   = (st == ST_SHIFT) && sh_msb;
        pins.ld_n  = !((st == ST_LOAD) && ph);
        pins.clr_n = (st != ST_CLEAR);
    end

    assign busy      = (st != ST_IDLE);
    assign dac_cs_n  = pins.cs_n;
    assign dac_sclk  = pins.sclk;
    assign dac_sdi   = pins.sdi;
    assign dac_ld_n  = pins.ld_n;
    assign dac_clr_n = pins.clr_n;

    // R5
    ld_outside_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !dac_ld_n |-> (dac_cs_n && !dac_sclk));
    // R3
    sclk_only_selected_chk: assert property (@(posedge clk) disable iff (rst)
        dac_sclk |-> !dac_cs_n);
    // R2
    sdi_hold_while_high_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdi));
    // R9
    busy_when_active_chk: assert property (@(posedge clk) disable iff (rst)
        (!dac_cs_n || !dac_ld_n || !dac_clr_n) |-> busy);
    // R7
    clr_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        !dac_clr_n |-> (dac_cs_n && dac_ld_n));
    // R10
    accept_selects_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !dac_cs_n);
endmodule

// File: tb/dac_load_seq_bench.sv
module dac_load_seq_bench;
    localparam int T_SEL = 2, T_CSH = 2, T_LO = 3, T_HI = 2;
    localparam int T_LDS = 2, T_LDW = 3, T_CLR = 4;
    // {busy, ready, cs_n, sclk, sdi, ld_n, clr_n}
    localparam logic [6:0] IDLE_V = 7'b0110011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] req_code = '0;
    logic        clr_req = 1'b0;
    logic        req_ready, busy, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, dac_clr_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit pend = 1'b0;
    string phase = "R1 reset";
    logic [6:0] exp_q[$];

    always #5 clk = ~clk;

    dac_load_seq #(
        .WORD_W(12), .T_SEL(T_SEL), .T_CSH(T_CSH), .T_CLK_LO(T_LO), .T_CLK_HI(T_HI),
        .T_LD_SETUP(T_LDS), .T_LD_W(T_LDW), .T_CLR_W(T_CLR)
    ) u_dac_load_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .clr_req(clr_req), .busy(busy), .dac_cs_n(dac_cs_n),
        .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n)
    );

    function automatic string field_req(input int i);
        case (i)
            6: return "R9 busy";
            5: return "R10 ready";
            4: return "R4 cs_n";
            3: return "R3 sclk";
            2: return "R2 sdi";
            1: return "R5 ld_n";
            default: return "R7 clr_n";
        endcase
    endfunction

    task automatic compare(input logic [6:0] expv);
        logic [6:0] act;
        act = {busy, req_ready, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, dac_clr_n};
        for (int i = 0; i < 7; i++) begin
            checks++;
            if (act[i] !== expv[i]) begin
                failures++;
                $display("FAIL %s [%s] cycle %0d act=%b exp=%b",
                         field_req(i), phase, cyc, act[i], expv[i]);
            end
        end
    endtask

    task automatic push_word(input logic [11:0] c);
        for (int k = 0; k < T_SEL; k++) exp_q.push_back(7'b1000011);
        for (int b = 11; b >= 0; b--) begin
            for (int k = 0; k < T_LO; k++) exp_q.push_back({5'b10000, 2'b00} | {4'b0, c[b], 2'b11});
            for (int k = 0; k < T_HI; k++) exp_q.push_back({5'b10010, 2'b00} | {4'b0, c[b], 2'b11});
        end
        for (int k = 0; k < T_CSH; k++) exp_q.push_back(7'b1000011);
        for (int k = 0; k < T_LDS; k++) exp_q.push_back(7'b1010011);
        for (int k = 0; k < T_LDW; k++) exp_q.push_back(7'b1010001);
        exp_q.push_back(7'b1010011);   // R6 final idle-level cycle
    endtask

    task automatic push_clear();
        for (int k = 0; k < T_CLR; k++) exp_q.push_back(7'b1010010);
    endtask

    task automatic step(input bit v, input logic [11:0] c, input bit cl);
        bit was_idle;
        @(negedge clk);
        cyc++;
        was_idle = (exp_q.size() == 0);
        compare(was_idle ? IDLE_V : exp_q.pop_front());
        req_valid = v;
        req_code  = c;
        clr_req   = cl;
        if (was_idle) begin
            if (v) begin
                push_word(c);
                pend = cl;          // R11 clear waits for the word
            end else if (cl) begin
                push_clear();
            end
        end else begin
            if (cl) pend = 1'b1;    // R8 deferred
            if (exp_q.size() == 0 && pend) begin
                push_clear();
                pend = 1'b0;
            end
        end
    endtask

    task automatic idle_for(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 12'h000, 1'b0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        phase = "R1 during reset";
        compare(IDLE_V);
        @(negedge clk);
        rst = 1'b0;

        phase = "R1 after reset";
        idle_for(2);

        phase = "R2 R3 R4 R5 R6 word A5C";
        step(1'b1, 12'hA5C, 1'b0);
        idle_for(75);

        phase = "R10 valid held while busy";
        step(1'b1, 12'hFFF, 1'b0);
        for (int i = 0; i < 100; i++) step(1'b1, 12'h123 + 12'(i), 1'b0);
        idle_for(80);

        phase = "R2 words 000 and 801";
        step(1'b1, 12'h000, 1'b0);
        idle_for(72);
        step(1'b1, 12'h801, 1'b0);
        idle_for(72);

        phase = "R7 clear in idle";
        step(1'b0, 12'h000, 1'b1);
        idle_for(8);

        phase = "R8 clear during shift";
        step(1'b1, 12'h3C3, 1'b0);
        idle_for(30);
        step(1'b0, 12'h000, 1'b1);
        idle_for(60);

        phase = "R8 clear during clear";
        step(1'b0, 12'h000, 1'b1);
        idle_for(2);
        step(1'b0, 12'h000, 1'b1);
        idle_for(12);

        phase = "R11 request with clear";
        step(1'b1, 12'h7FF, 1'b1);
        idle_for(85);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule